// File: doc/BRIEF.md
# Timed Sine Tone Burst Generator with PWM Output

This block synthesises a sine tone digitally and presents it on a single pulse-width-modulated pin. A 16-bit phase register grows by a programmable step on every reference tick, wrapping modulo 2^16. The step sets the pitch: step = f_out * 2^16 / f_tick, where f_tick is the reference tick rate (38400 ticks per second by default). At that rate a step of 2048 gives 1200 Hz and a step of 3755 gives about 2200 Hz. The ten most significant phase bits select one entry of a 1024-entry sine table. The table is computed when the design is elaborated. Each entry is cut to a 6-bit duty value, and that value drives a free-running 64-step PWM counter.

Each tone is a burst of fixed length. A start strobe loads a tick count. The burst controller then passes one table sample per tick until the count runs out. On the next tick it forces the duty to zero and returns to idle. A stop strobe ends a burst at once. The phase register advances on every tick, in idle as well, so the waveform phase carries on from one burst to the next. The burst controller is a two-state machine:

- ST_IDLE: no tone is playing. The transition GO (start without stop) leads to ST_PLAY.
- ST_PLAY: a tone is playing. HALT (stop) and EXPIRE (a tick while the remaining count is zero) lead back to ST_IDLE. RELOAD (start without stop) stays in ST_PLAY and loads a new count.

Top module: `tone_burst_pwm`

## Requirements
- R1: While reset is asserted, and on leaving it, busy is 0, pwm_out is 0, and the phase register, the remaining count and both duty registers (pending and applied) are 0.
- R2: On each clock with tick_en high, the phase register becomes (phase + step) mod 2^16, in ST_IDLE as well as in ST_PLAY. On clocks without tick_en, the phase register holds its value.
- R3: For table index k, the table holds the value 128 + round(127.5*sin(2*pi*k/1024)), clamped to the range 0..255. On a tick in ST_PLAY, the index is bits [15:6] of the updated phase. The duty value is that entry shifted right by 2 (bits [7:2] of the entry).
- R4: The PWM counter runs from 0 to 63 on every clock and then wraps to 0. pwm_out is high while the counter is below the applied duty. The pending duty becomes the applied duty only on the clock where the counter wraps from 63 to 0.
- R5: A start with duration D loads D and enters ST_PLAY. The next D ticks each load a table sample into the pending duty. Tick D+1 sets the pending duty to 0 and returns to ST_IDLE. With D = 0, the first tick ends the burst.
- R6: A stop clears busy and sets the pending duty to 0. The phase register is not affected.
- R7: If start and stop occur on the same clock, stop wins: the block ends up in ST_IDLE with a pending duty of 0.
- R8: Without tick_en, neither the pending duty nor the remaining count changes. A burst can therefore pause between ticks.
- R9: busy is 1 exactly while the controller is in ST_PLAY. A start in ST_PLAY (RELOAD) reloads the duration and keeps busy high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Reference tick enable, one clock wide |
| step | input | 16 | Phase increment added on each tick |
| dur | input | 16 | Burst length in ticks, loaded by start |
| start | input | 1 | Begin or restart a burst |
| stop | input | 1 | Abort the burst; has priority over start |
| busy | output | 1 | High while a burst is playing |
| pwm_out | output | 1 | Non-inverting PWM tone output |

## Verification
The bench sends one tick per PWM period. It measures each period's high time, which must equal the duty applied at that period's start. This catches a design that changes the duty in the middle of a period, or that indexes the table with the old phase instead of the updated one. The durations tested are 0, 2, 3 and 5 ticks, and the bench checks that the burst lasts D ticks plus one ending tick. A design with an off-by-one terminal count would play a sample too many or too few. Idle ticks between bursts, and a simultaneous start and stop, show whether the phase keeps running and whether stop wins. A design that froze the phase in idle, or let start win, would play the wrong samples or stay busy. A long sweep over scattered step values, including a quarter-turn step, reaches the table's peak (duty 63) and floor (duty 0).

// File: rtl/tone_burst_pkg.sv
package tone_burst_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PLAY = 1'b1
    } burst_state_e;

    // Offset-binary sine entry: mid + round(amp*sin), clamped to [0, 2^w-1]
    function automatic int sine_entry(input int k, input int depth, input int w);
        real amp;
        real x;
        int  r;
        int  top;
        amp = ((2.0 ** w) - 1.0) / 2.0;
        x   = amp * $sin(2.0 * 3.14159265358979323846 * k / depth);
        if (x >= 0.0) r = $rtoi(x + 0.5);
        else          r = -$rtoi(0.5 - x);
        r   = r + (2 ** (w - 1));
        top = (2 ** w) - 1;
        if (r < 0)   r = 0;
        if (r > top) r = top;
        return r;
    endfunction

endpackage

// File: rtl/phase_accum.sv
module phase_accum #(
    parameter int PHASE_W = 16,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic [PHASE_W-1:0] step,
    output logic [PHASE_W-1:0] phase_q,
    output logic [ADDR_W-1:0]  next_idx
);
    logic [PHASE_W-1:0] phase_next;

    assign phase_next = phase_q + step;
    assign next_idx   = phase_next[PHASE_W-1 -: ADDR_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       phase_q <= '0;
        else if (tick_en) phase_q <= phase_next;
    end
endmodule

// File: rtl/sine_cmp_rom.sv
module sine_cmp_rom #(
    parameter int ADDR_W   = 10,
    parameter int SAMPLE_W = 8,
    parameter int OUT_W    = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [OUT_W-1:0]  cmp
);
    localparam int DEPTH = 2 ** ADDR_W;
    localparam int DROP  = SAMPLE_W - OUT_W;

    logic [OUT_W-1:0] tbl [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam int FULL = tone_burst_pkg::sine_entry(k, DEPTH, SAMPLE_W);
        localparam int CUT  = FULL >> DROP;
        assign tbl[k] = CUT[OUT_W-1:0];
    end

    assign cmp = tbl[addr];
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import tone_burst_pkg::*;
#(
    parameter int DUR_W = 16,
    parameter int CMP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             start,
    input  logic             stop,
    input  logic [DUR_W-1:0] dur,
    input  logic [CMP_W-1:0] sample_cmp,
    output logic             busy,
    output logic [CMP_W-1:0] cmp_pend
);
    burst_state_e     state_q, state_d;
    logic [DUR_W-1:0] remain_q;
    logic             expire;

    assign expire = tick_en && (remain_q == '0);

    // Next state: GO, RELOAD, HALT, EXPIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start && !stop) state_d = ST_PLAY;
            ST_PLAY: begin
                if (stop)        state_d = ST_IDLE;
                else if (start)  state_d = ST_PLAY;
                else if (expire) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            cmp_pend <= '0;
        end else if (stop) begin
            cmp_pend <= '0;
        end else if (start) begin
            remain_q <= dur;
        end else if (tick_en && state_q == ST_PLAY) begin
            cmp_pend <= expire ? '0 : sample_cmp;
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy = (state_q == ST_PLAY);
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen #(
    parameter int CMP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] cmp_pend,
    output logic             pwm_out
);
    logic [CMP_W-1:0] cnt_q;
    logic [CMP_W-1:0] act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == '1) act_q <= cmp_pend;
        end
    end

    assign pwm_out = (cnt_q < act_q);
endmodule

// File: rtl/tone_burst_pwm.sv
module tone_burst_pwm #(
    parameter int PHASE_W  = 16,
    parameter int ADDR_W   = 10,
    parameter int SAMPLE_W = 8,
    parameter int CMP_W    = 6,
    parameter int DUR_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic [PHASE_W-1:0] step,
    input  logic [DUR_W-1:0]   dur,
    input  logic               start,
    input  logic               stop,
    output logic               busy,
    output logic               pwm_out
);
    logic [PHASE_W-1:0] phase_q;
    logic [ADDR_W-1:0]  next_idx;
    logic [CMP_W-1:0]   sample_cmp;
    logic [CMP_W-1:0]   cmp_pend;

    phase_accum #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .step(step),
        .phase_q(phase_q), .next_idx(next_idx)
    );

    sine_cmp_rom #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W), .OUT_W(CMP_W)) u_rom (
        .addr(next_idx), .cmp(sample_cmp)
    );

    burst_ctrl #(.DUR_W(DUR_W), .CMP_W(CMP_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start), .stop(stop),
        .dur(dur), .sample_cmp(sample_cmp), .busy(busy), .cmp_pend(cmp_pend)
    );

    pwm_gen #(.CMP_W(CMP_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .cmp_pend(cmp_pend), .pwm_out(pwm_out)
    );
endmodule

// File: rtl/tone_burst_pwm_chk.sv
module tone_burst_pwm_chk #(
    parameter int PHASE_W = 16,
    parameter int CMP_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_en,
    input logic               start,
    input logic               stop,
    input logic [PHASE_W-1:0] step,
    input logic               busy,
    input logic [PHASE_W-1:0] acc,
    input logic [CMP_W-1:0]   cnt,
    input logic [CMP_W-1:0]   cmp_act,
    input logic [CMP_W-1:0]   cmp_pend
);
    p_acc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> acc == $past(acc) + $past(step));

    p_acc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(acc));

    p_cmp_wrap_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '1) |=> $stable(cmp_act));

    p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!busy && cmp_pend == '0));

    p_stop_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && stop) |=> !busy);

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> busy);

    p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !stop) |=> $stable(cmp_pend));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(cmp_pend));
endmodule

bind tone_burst_pwm tone_burst_pwm_chk #(.PHASE_W(PHASE_W), .CMP_W(CMP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start), .stop(stop),
    .step(step), .busy(busy), .acc(u_acc.phase_q), .cnt(u_pwm.cnt_q),
    .cmp_act(u_pwm.act_q), .cmp_pend(cmp_pend)
);

// File: tb/tone_burst_pwm_tb.sv
`timescale 1ns/1ps
module tone_burst_pwm_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [15:0] step = '0;
    logic [15:0] dur = '0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        busy;
    logic        pwm_out;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    // reference model state
    int m_acc  = 0;
    int m_rem  = 0;
    int m_pend = 0;
    bit m_run  = 1'b0;
    int exp_tbl [1024];

    localparam int C_NONE = 0, C_START = 1, C_STOP = 2, C_BOTH = 3;

    always #2.5 clk = ~clk;

    tone_burst_pwm u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .step(step), .dur(dur),
        .start(start), .stop(stop), .busy(busy), .pwm_out(pwm_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog: actual %0d cycles, expected under 190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One PWM period (64 clocks). Command at slot 16, tick at slot 32.
    // R4: high time of a period equals the duty applied at its start.
    task automatic period(input int cmd, input int d, input bit tk, input int stp, input string tag);
        int hi;
        int exp_act;
        hi = 0;
        exp_act = m_pend;
        for (int j = 0; j < 64; j++) begin
            @(negedge clk);
            if (pwm_out) hi++;
            if (j == 16) begin
                start = (cmd == C_START) || (cmd == C_BOTH);
                stop  = (cmd == C_STOP)  || (cmd == C_BOTH);
                dur   = d[15:0];
                if (stop) begin
                    m_run = 1'b0; m_pend = 0;        // R6, R7
                end else if (start) begin
                    m_run = 1'b1; m_rem = d;         // R5, R9
                end
            end
            if (j == 17) begin
                start = 1'b0; stop = 1'b0;
            end
            if (j == 32 && tk) begin
                tick_en = 1'b1;
                step    = stp[15:0];
                m_acc   = (m_acc + stp) & 16'hFFFF;  // R2
                if (m_run) begin
                    if (m_rem == 0) begin
                        m_pend = 0; m_run = 1'b0;    // R5 expire
                    end else begin
                        m_pend = exp_tbl[m_acc >> 6] >> 2;  // R3
                    end
                    m_rem = (m_rem - 1) & 16'hFFFF;
                end
            end
            if (j == 33) tick_en = 1'b0;
            if (j == 40) check({tag, " R9 busy"}, int'(busy), int'(m_run));
        end
        check({tag, " R4 duty"}, hi, exp_act);
    endtask

    initial begin
        // R3 table from the stated formula
        for (int k = 0; k < 1024; k++) begin
            real x;
            int  r;
            x = 127.5 * $sin(2.0 * 3.14159265358979323846 * k / 1024.0);
            if (x >= 0.0) r = $rtoi(x + 0.5);
            else          r = -$rtoi(0.5 - x);
            r = r + 128;
            if (r < 0) r = 0;
            if (r > 255) r = 255;
            exp_tbl[k] = r;
        end
        check("R3 table entry 0", exp_tbl[0], 128);
        check("R3 table peak", exp_tbl[256], 255);
        check("R3 table floor", exp_tbl[768], 0);

        repeat (4) @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 pwm in reset", int'(pwm_out), 0);
        rst_n = 1'b1;                 // at a negedge: counter reads 0 here
        repeat (63) @(negedge clk);   // next period task starts at counter 0

        period(C_NONE, 0, 1'b0, 0, "R1 idle");
        period(C_NONE, 0, 1'b0, 0, "R1 idle");
        // R2: phase runs while idle
        for (int i = 0; i < 3; i++) period(C_NONE, 0, 1'b1, 2048, "R2 idle tick");
        // R5: burst of 5 at 1200 Hz
        period(C_START, 5, 1'b1, 2048, "R5 start d5");
        for (int i = 0; i < 6; i++) period(C_NONE, 0, 1'b1, 2048, "R5 burst");
        period(C_NONE, 0, 1'b1, 3755, "R2 idle 2200");
        period(C_NONE, 0, 1'b1, 3755, "R2 idle 2200");
        // burst of 3 at 2200 Hz
        period(C_START, 3, 1'b1, 3755, "R5 start d3");
        for (int i = 0; i < 4; i++) period(C_NONE, 0, 1'b1, 3755, "R5 burst d3");
        // R5 boundary: duration zero
        period(C_START, 0, 1'b0, 0, "R5 d0 armed");
        period(C_NONE, 0, 1'b1, 2048, "R5 d0 expire");
        period(C_NONE, 0, 1'b1, 2048, "R5 d0 after");
        // R8 pause, R6 stop
        period(C_START, 20, 1'b1, 5000, "R8 start");
        period(C_NONE, 0, 1'b1, 5000, "R8 run");
        period(C_NONE, 0, 1'b0, 0, "R8 no tick");
        period(C_NONE, 0, 1'b0, 0, "R8 no tick");
        period(C_NONE, 0, 1'b1, 5000, "R8 resume");
        period(C_STOP, 0, 1'b1, 5000, "R6 stop");
        period(C_NONE, 0, 1'b1, 5000, "R6 after stop");
        period(C_NONE, 0, 1'b1, 5000, "R6 phase kept");
        // R7: start and stop together
        period(C_BOTH, 9, 1'b1, 1234, "R7 both");
        period(C_NONE, 0, 1'b1, 1234, "R7 after");
        // R9 RELOAD while playing
        period(C_START, 10, 1'b1, 700, "R9 start");
        period(C_START, 2, 1'b1, 700, "R9 reload");
        for (int i = 0; i < 3; i++) period(C_NONE, 0, 1'b1, 700, "R9 reload run");
        // R3 peak/floor by quarter-turn step, then scattered sweep
        period(C_START, 1000, 1'b1, 16384, "R3 quarter");
        for (int i = 0; i < 6; i++) period(C_NONE, 0, 1'b1, 16384, "R3 quarter");
        for (int i = 0; i < 150; i++)
            period(C_NONE, 0, 1'b1, (i * 2477 + 123) & 16'hFFFF, "R3 sweep");
        period(C_STOP, 0, 1'b0, 0, "R6 final stop");
        period(C_NONE, 0, 1'b0, 0, "R6 final idle");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule